// File: doc/BRIEF.md
# PLL Retune Sequencer

This block retunes the on-chip PLLs one request at a time, so that no clock consumer ever sees a PLL while it is being reprogrammed. A request names a target PLL and gives three dividers: the reference divider NR, the feedback multiplier NF and the post divider NO. It may also name a second PLL, which is then retuned together with the first using the same dividers. Before any register is touched, the sequencer checks the request against the limits of the VCO and the output. A request that fails the check ends with an error pulse and changes nothing.

An accepted request runs a fixed sequence. The target's clock mux moves to the crystal oscillator. Then its reset goes on, and the divider fields are loaded in their minus-one encoding, with a bandwidth field derived from NF. The sequencer waits a settle time measured in microseconds and releases reset. It then polls the lock bits of a shared status word once per microsecond. When every target reports lock, the muxes go back to the PLL outputs in a single cycle and a done pulse is given. If lock does not arrive within a timeout, an error pulse is given instead and the PLL is left on the oscillator.

The microsecond time base comes from a prescaler sized by the system clock frequency. The analog PLLs sit outside the block.

Top module: `pll_retune_seq`

## Requirements
- R1: A request (`req_valid` high) is taken only while `busy` is low. `busy` is high from the cycle after acceptance until the cycle in which `done` or `err` pulses for one cycle, and these two never pulse together. A request presented while `busy` is high has no effect.
- R2: A request is valid only if all of the following hold. NR is not 0. NO is 1 or an even value no greater than 16. Every named index is below NUM_PLL. In pair mode the two indices differ. REF_KHZ·NF lies within [440000·NR, 2200000·NR] kHz (VCO range, inclusive). REF_KHZ·NF lies within [27500·NR·NO, 2200000·NR·NO] kHz (output range, inclusive). The default REF_KHZ is 24000. An invalid request pulses `err` and leaves every output other than `busy` unchanged.
- R3: For each target, the mode bit (`pll_mode[i]`, 1 = PLL output, 0 = oscillator) drops first. The reset bit `pll_rst[i]` rises the following cycle. Divider fields change only while `pll_rst[i]` is high.
- R4: Each PLL i has its own field slices at offset i times the field width. The post divider field (4 bits) receives NO-1, the reference field (6 bits) receives NR-1, the feedback field (13 bits) receives NF-1 and the bandwidth field (12 bits) receives (NF>>1)-1.
- R5: `pll_rst[i]` stays high for at least SETTLE_US·CLK_MHZ cycles and at most 4 cycles more, so the dividers settle for SETTLE_US microseconds before release.
- R6: The lock bit of PLL i is bit LOCK_LSB+i of `lock_stat` (bits 5..9 by default), and the other bits are ignored. `pll_mode[i]` returns to 1 only while that lock bit is high, and `done` pulses in the same cycle.
- R7: If lock is not seen within LOCK_TMO_US microseconds after reset release, `err` pulses. The PLL is left with `pll_mode[i]`=0, `pll_rst[i]`=0 and the new fields.
- R8: In pair mode both PLLs receive the same fields. Neither returns to mode 1 until both lock bits are high, and both return in the same cycle.
- R9: A PLL that is not a target of the current request keeps all of its outputs.
- R10: After reset, `busy`, `done` and `err` are 0, all `pll_mode` bits are 1, all `pll_rst` bits are 0 and all fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_pair | input | 1 | Retune a second PLL together with the first |
| req_idx_a | input | 3 | First target PLL index |
| req_idx_b | input | 3 | Second target PLL index (pair mode) |
| req_nr | input | 6 | Reference divider NR |
| req_nf | input | 13 | Feedback multiplier NF |
| req_no | input | 5 | Post divider NO |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: retune finished, PLL(s) back on line |
| err | output | 1 | One-cycle pulse: request rejected or lock timeout |
| pll_mode | output | 5 | Per-PLL mux select, 1 = PLL, 0 = oscillator |
| pll_rst | output | 5 | Per-PLL reset |
| pll_od | output | 20 | Post divider fields, 4 bits per PLL |
| pll_ref | output | 30 | Reference divider fields, 6 bits per PLL |
| pll_fb | output | 65 | Feedback fields, 13 bits per PLL |
| pll_bw | output | 60 | Bandwidth fields, 12 bits per PLL |
| lock_stat | input | 16 | Status word carrying the per-PLL lock bits |

## Verification
The bench drives inclusive edge cases on both sides of the VCO limits: exactly 440 MHz with a 27.5 MHz output, exactly 2200 MHz, and one step outside each. A checker that divides with truncation, or that uses strict comparisons, flips at least one verdict and sets fields it should leave alone. It also sends odd and oversized NO values, a zero NR, out-of-range and duplicate indices, and a request issued mid-sequence. A block that fails to ignore that last request would emit a second completion. The bench also runs a pair in which the second PLL locks late, and a PLL that never locks. A design that un-bypasses on the first lock, or on a stray status bit, would raise a mux while a lock bit is low, and one without the timeout would hang. Ordering monitors flag any field written outside reset, any reset raised before the bypass, and any settle window shorter than ten microseconds.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK,
    S_SLOW,
    S_RESET,
    S_PROG,
    S_SETTLE,
    S_RELEASE,
    S_LOCK
  } seq_state_t;

  // one-cycle control strobes applied to the selected PLLs
  typedef struct packed {
    logic to_slow;
    logic to_norm;
    logic rst_on;
    logic rst_off;
    logic wr;
  } pll_ctl_t;

endpackage

// File: rtl/pll_seq_validate.sv
module pll_seq_validate #(
  parameter int NUM_PLL     = 5,
  parameter int IDX_W       = 3,
  parameter int NR_W        = 6,
  parameter int NF_W        = 13,
  parameter int NO_W        = 4,
  parameter int REF_KHZ     = 24000,
  parameter int VCO_MIN_KHZ = 440000,
  parameter int VCO_MAX_KHZ = 2200000,
  parameter int OUT_MIN_KHZ = 27500,
  parameter int OUT_MAX_KHZ = 2200000
) (
  input  logic [IDX_W-1:0] idx_a,
  input  logic [IDX_W-1:0] idx_b,
  input  logic             pair,
  input  logic [NR_W-1:0]  nr,
  input  logic [NF_W-1:0]  nf,
  input  logic [NO_W:0]    no,
  output logic             ok
);

  localparam int MW = 48;
  localparam logic [MW-1:0] REF_V  = MW'(REF_KHZ);
  localparam logic [MW-1:0] VMIN_V = MW'(VCO_MIN_KHZ);
  localparam logic [MW-1:0] VMAX_V = MW'(VCO_MAX_KHZ);
  localparam logic [MW-1:0] OMIN_V = MW'(OUT_MIN_KHZ);
  localparam logic [MW-1:0] OMAX_V = MW'(OUT_MAX_KHZ);
  localparam logic [NO_W:0] NO_MAX = {1'b1, {NO_W{1'b0}}};
  localparam logic [IDX_W:0] NPLL_V = (IDX_W+1)'(NUM_PLL);

  logic [MW-1:0] prod, nr_x, nrno;
  logic vco_ok, out_ok, no_ok, idx_ok;

  // exact rational range tests: no divider in the path
  always_comb begin
    prod   = REF_V * MW'(nf);
    nr_x   = MW'(nr);
    nrno   = nr_x * MW'(no);
    vco_ok = (prod >= VMIN_V * nr_x) && (prod <= VMAX_V * nr_x);
    out_ok = (prod >= OMIN_V * nrno) && (prod <= OMAX_V * nrno);
    no_ok  = (no != '0) && (no <= NO_MAX) && ((no == (NO_W+1)'(1)) || !no[0]);
    idx_ok = ({1'b0, idx_a} < NPLL_V) &&
             (!pair || (({1'b0, idx_b} < NPLL_V) && (idx_a != idx_b)));
    ok     = (nr != '0) && no_ok && idx_ok && vco_ok && out_ok;
  end

endmodule

// File: rtl/pll_seq_ustick.sv
module pll_seq_ustick #(
  parameter int CLK_MHZ = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);

  localparam int PW = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLK_MHZ - 1);

  logic [PW-1:0] pre_q, pre_d;

  always_comb begin
    tick  = (pre_q == LAST) && !clr;
    pre_d = pre_q;
    if (clr || tick) pre_d = '0;
    else             pre_d = pre_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

endmodule

// File: rtl/pll_seq_bank.sv
module pll_seq_bank
  import pll_seq_pkg::*;
#(
  parameter int NUM_PLL = 5,
  parameter int NR_W    = 6,
  parameter int NF_W    = 13,
  parameter int NO_W    = 4,
  parameter int BW_W    = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_PLL-1:0]      sel,
  input  pll_ctl_t                ctl,
  input  logic [NO_W-1:0]         od_d,
  input  logic [NR_W-1:0]         ref_d,
  input  logic [NF_W-1:0]         fb_d,
  input  logic [BW_W-1:0]         bw_d,
  output logic [NUM_PLL-1:0]      mode_q,
  output logic [NUM_PLL-1:0]      prst_q,
  output logic [NUM_PLL*NO_W-1:0] od_q,
  output logic [NUM_PLL*NR_W-1:0] ref_q,
  output logic [NUM_PLL*NF_W-1:0] fb_q,
  output logic [NUM_PLL*BW_W-1:0] bw_q
);

  for (genvar i = 0; i < NUM_PLL; i++) begin : g_pll
    logic            mode_r, prst_r;
    logic [NO_W-1:0] od_r;
    logic [NR_W-1:0] ref_r;
    logic [NF_W-1:0] fb_r;
    logic [BW_W-1:0] bw_r;
    logic            mode_en, prst_en, fld_en;

    assign mode_en = sel[i] && (ctl.to_slow || ctl.to_norm);
    assign prst_en = sel[i] && (ctl.rst_on || ctl.rst_off);
    assign fld_en  = sel[i] && ctl.wr;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_r <= 1'b1;
        prst_r <= 1'b0;
      end else begin
        if (mode_en) mode_r <= ctl.to_norm;
        if (prst_en) prst_r <= ctl.rst_on;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        od_r  <= '0;
        ref_r <= '0;
        fb_r  <= '0;
        bw_r  <= '0;
      end else if (fld_en) begin
        od_r  <= od_d;
        ref_r <= ref_d;
        fb_r  <= fb_d;
        bw_r  <= bw_d;
      end
    end

    assign mode_q[i]                 = mode_r;
    assign prst_q[i]                 = prst_r;
    assign od_q[i*NO_W +: NO_W]      = od_r;
    assign ref_q[i*NR_W +: NR_W]     = ref_r;
    assign fb_q[i*NF_W +: NF_W]      = fb_r;
    assign bw_q[i*BW_W +: BW_W]      = bw_r;
  end

endmodule

// File: rtl/pll_retune_seq.sv
module pll_retune_seq
  import pll_seq_pkg::*;
#(
  parameter int NUM_PLL     = 5,
  parameter int CLK_MHZ     = 8,
  parameter int REF_KHZ     = 24000,
  parameter int SETTLE_US   = 10,
  parameter int LOCK_TMO_US = 50,
  parameter int STAT_W      = 16,
  parameter int LOCK_LSB    = 5,
  parameter int NR_W        = 6,
  parameter int NF_W        = 13,
  parameter int NO_W        = 4,
  parameter int BW_W        = 12,
  parameter int VCO_MIN_KHZ = 440000,
  parameter int VCO_MAX_KHZ = 2200000,
  parameter int OUT_MIN_KHZ = 27500,
  parameter int OUT_MAX_KHZ = 2200000,
  localparam int IDX_W      = (NUM_PLL > 1) ? $clog2(NUM_PLL) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_pair,
  input  logic [IDX_W-1:0]        req_idx_a,
  input  logic [IDX_W-1:0]        req_idx_b,
  input  logic [NR_W-1:0]         req_nr,
  input  logic [NF_W-1:0]         req_nf,
  input  logic [NO_W:0]           req_no,
  output logic                    busy,
  output logic                    done,
  output logic                    err,
  output logic [NUM_PLL-1:0]      pll_mode,
  output logic [NUM_PLL-1:0]      pll_rst,
  output logic [NUM_PLL*NO_W-1:0] pll_od,
  output logic [NUM_PLL*NR_W-1:0] pll_ref,
  output logic [NUM_PLL*NF_W-1:0] pll_fb,
  output logic [NUM_PLL*BW_W-1:0] pll_bw,
  input  logic [STAT_W-1:0]       lock_stat
);

  localparam int CNT_MAX = (SETTLE_US > LOCK_TMO_US) ? SETTLE_US : LOCK_TMO_US;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_US - 1);
  localparam logic [CNT_W-1:0] TMO_LAST    = CNT_W'(LOCK_TMO_US - 1);

  seq_state_t state_q, state_d;
  pll_ctl_t   ctl;

  logic             cap_en, cnt_clr, cnt_inc, tmr_clr, tick;
  logic             done_d, err_d, done_q, err_q, req_ok, all_locked;
  logic [IDX_W-1:0] cap_a, cap_b;
  logic             cap_pair;
  logic [NR_W-1:0]  cap_nr;
  logic [NF_W-1:0]  cap_nf;
  logic [NO_W:0]    cap_no;
  logic [NUM_PLL-1:0] mask_d, mask_q;
  logic [NUM_PLL-1:0] lock_raw, lock_m, lock_s;
  logic [CNT_W-1:0] us_cnt;
  logic [NO_W-1:0]  od_d;
  logic [NR_W-1:0]  ref_d;
  logic [NF_W-1:0]  fb_d;
  logic [BW_W-1:0]  bw_d;
  logic             unused_stat_bits;

  // ---- lock bit decode and synchronizer ----
  for (genvar i = 0; i < NUM_PLL; i++) begin : g_lock
    assign lock_raw[i] = lock_stat[LOCK_LSB + i];
  end
  assign unused_stat_bits = ^lock_stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_m <= '0;
      lock_s <= '0;
    end else begin
      lock_m <= lock_raw;
      lock_s <= lock_m;
    end
  end

  assign all_locked = ((lock_s & mask_q) == mask_q);

  // ---- request capture ----
  assign mask_d = (NUM_PLL'(1) << req_idx_a) |
                  (req_pair ? (NUM_PLL'(1) << req_idx_b) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a    <= '0;
      cap_b    <= '0;
      cap_pair <= 1'b0;
      cap_nr   <= '0;
      cap_nf   <= '0;
      cap_no   <= '0;
      mask_q   <= '0;
    end else if (cap_en) begin
      cap_a    <= req_idx_a;
      cap_b    <= req_idx_b;
      cap_pair <= req_pair;
      cap_nr   <= req_nr;
      cap_nf   <= req_nf;
      cap_no   <= req_no;
      mask_q   <= mask_d;
    end
  end

  pll_seq_validate #(
    .NUM_PLL(NUM_PLL), .IDX_W(IDX_W), .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W),
    .REF_KHZ(REF_KHZ), .VCO_MIN_KHZ(VCO_MIN_KHZ), .VCO_MAX_KHZ(VCO_MAX_KHZ),
    .OUT_MIN_KHZ(OUT_MIN_KHZ), .OUT_MAX_KHZ(OUT_MAX_KHZ)
  ) u_val (
    .idx_a(cap_a), .idx_b(cap_b), .pair(cap_pair),
    .nr(cap_nr), .nf(cap_nf), .no(cap_no), .ok(req_ok)
  );

  // ---- field encodings ----
  assign od_d  = NO_W'(cap_no - (NO_W+1)'(1));
  assign ref_d = cap_nr - NR_W'(1);
  assign fb_d  = cap_nf - NF_W'(1);
  assign bw_d  = BW_W'((cap_nf >> 1) - NF_W'(1));

  // ---- microsecond base ----
  pll_seq_ustick #(.CLK_MHZ(CLK_MHZ)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       us_cnt <= '0;
    else if (cnt_clr) us_cnt <= '0;
    else if (cnt_inc) us_cnt <= us_cnt + CNT_W'(1);
  end

  // ---- sequencer ----
  always_comb begin
    state_d = state_q;
    ctl     = '0;
    cap_en  = 1'b0;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    tmr_clr = 1'b0;
    done_d  = 1'b0;
    err_d   = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          cap_en  = 1'b1;
          state_d = S_CHECK;
        end
      end
      S_CHECK: begin
        if (req_ok) state_d = S_SLOW;
        else begin
          err_d   = 1'b1;
          state_d = S_IDLE;
        end
      end
      S_SLOW: begin
        ctl.to_slow = 1'b1;
        state_d     = S_RESET;
      end
      S_RESET: begin
        ctl.rst_on = 1'b1;
        state_d    = S_PROG;
      end
      S_PROG: begin
        ctl.wr  = 1'b1;
        tmr_clr = 1'b1;
        cnt_clr = 1'b1;
        state_d = S_SETTLE;
      end
      S_SETTLE: begin
        if (tick) begin
          if (us_cnt == SETTLE_LAST) state_d = S_RELEASE;
          else                       cnt_inc = 1'b1;
        end
      end
      S_RELEASE: begin
        ctl.rst_off = 1'b1;
        tmr_clr     = 1'b1;
        cnt_clr     = 1'b1;
        state_d     = S_LOCK;
      end
      S_LOCK: begin
        if (tick) begin
          if (all_locked) begin
            ctl.to_norm = 1'b1;
            done_d      = 1'b1;
            state_d     = S_IDLE;
          end else if (us_cnt == TMO_LAST) begin
            err_d   = 1'b1;
            state_d = S_IDLE;
          end else begin
            cnt_inc = 1'b1;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  pll_seq_bank #(
    .NUM_PLL(NUM_PLL), .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .BW_W(BW_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .sel(mask_q), .ctl(ctl),
    .od_d(od_d), .ref_d(ref_d), .fb_d(fb_d), .bw_d(bw_d),
    .mode_q(pll_mode), .prst_q(pll_rst),
    .od_q(pll_od), .ref_q(pll_ref), .fb_q(pll_fb), .bw_q(pll_bw)
  );

  assign busy = (state_q != S_IDLE);
  assign done = done_q;
  assign err  = err_q;

endmodule

// File: rtl/pll_retune_seq_chk.sv
module pll_retune_seq_chk #(
  parameter int NUM_PLL   = 5,
  parameter int CLK_MHZ   = 8,
  parameter int SETTLE_US = 10,
  parameter int STAT_W    = 16,
  parameter int LOCK_LSB  = 5,
  parameter int NF_W      = 13,
  parameter int NO_W      = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    busy,
  input logic                    done,
  input logic                    err,
  input logic [NUM_PLL-1:0]      pll_mode,
  input logic [NUM_PLL-1:0]      pll_rst,
  input logic [NUM_PLL*NO_W-1:0] pll_od,
  input logic [NUM_PLL*NF_W-1:0] pll_fb,
  input logic [STAT_W-1:0]       lock_stat
);

  localparam int unsigned SETTLE_CYC = SETTLE_US * CLK_MHZ;

  logic unused_chk_bits;
  assign unused_chk_bits = ^lock_stat;

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err)) else $error("done and err together"); // R1

  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || err)) else $error("busy fell without completion"); // R1

  AST_IDLE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !busy) else $error("completion while busy"); // R1

  for (genvar i = 0; i < NUM_PLL; i++) begin : g_pll
    int unsigned hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          hi_cnt <= 0;
      else if (pll_rst[i]) hi_cnt <= hi_cnt + 1;
      else                 hi_cnt <= 0;
    end

    AST_FIELD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({pll_od[i*NO_W +: NO_W], pll_fb[i*NF_W +: NF_W]}) |-> pll_rst[i])
      else $error("field written outside reset"); // R3

    AST_RESET_AFTER_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_rst[i]) |-> !pll_mode[i]) else $error("reset while on PLL"); // R3

    AST_NORMAL_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      pll_mode[i] |-> !pll_rst[i]) else $error("PLL selected while in reset"); // R3

    AST_SETTLE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pll_rst[i]) |-> (hi_cnt >= SETTLE_CYC)) else $error("settle too short"); // R5

    AST_UNBYPASS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_mode[i]) |-> $past(lock_stat[LOCK_LSB + i])) else $error("un-bypass without lock"); // R6

    AST_UNBYPASS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_mode[i]) |-> done) else $error("un-bypass without done"); // R6
  end

endmodule

bind pll_retune_seq pll_retune_seq_chk #(
  .NUM_PLL(NUM_PLL), .CLK_MHZ(CLK_MHZ), .SETTLE_US(SETTLE_US),
  .STAT_W(STAT_W), .LOCK_LSB(LOCK_LSB), .NF_W(NF_W), .NO_W(NO_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .pll_mode(pll_mode), .pll_rst(pll_rst), .pll_od(pll_od), .pll_fb(pll_fb),
  .lock_stat(lock_stat)
);

// File: tb/sim_pll_retune_seq.sv
module sim_pll_retune_seq;

  localparam int CLK_PERIOD = 10;
  localparam int NP   = 5;
  localparam int CMHZ = 8;
  localparam int SUS  = 10;
  localparam int NRW  = 6;
  localparam int NFW  = 13;
  localparam int NOW  = 4;
  localparam int BWW  = 12;
  localparam int K_OK = 0, K_BAD = 1, K_TMO = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_pair;
  logic [2:0] req_idx_a, req_idx_b;
  logic [NRW-1:0] req_nr;
  logic [NFW-1:0] req_nf;
  logic [NOW:0]   req_no;
  logic busy, done, err;
  logic [NP-1:0] pll_mode, pll_rst;
  logic [NP*NOW-1:0] pll_od;
  logic [NP*NRW-1:0] pll_ref;
  logic [NP*NFW-1:0] pll_fb;
  logic [NP*BWW-1:0] pll_bw;
  logic [15:0] lock_stat;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_retune_seq #(.NUM_PLL(NP), .CLK_MHZ(CMHZ), .SETTLE_US(SUS)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pair(req_pair),
    .req_idx_a(req_idx_a), .req_idx_b(req_idx_b), .req_nr(req_nr),
    .req_nf(req_nf), .req_no(req_no), .busy(busy), .done(done), .err(err),
    .pll_mode(pll_mode), .pll_rst(pll_rst), .pll_od(pll_od), .pll_ref(pll_ref),
    .pll_fb(pll_fb), .pll_bw(pll_bw), .lock_stat(lock_stat)
  );

  // ---- analog PLL model: lock rises ldly cycles after reset release ----
  int lcnt [NP];
  int ldly [NP];
  logic [NP-1:0] dead;
  logic [NP-1:0] lk;

  always @(posedge clk) begin
    for (int i = 0; i < NP; i++) begin
      if (pll_rst[i]) lcnt[i] <= 0;
      else if (!dead[i] && lcnt[i] < ldly[i]) lcnt[i] <= lcnt[i] + 1;
    end
  end
  always_comb begin
    for (int i = 0; i < NP; i++) lk[i] = (lcnt[i] >= ldly[i]) && !dead[i] && !pll_rst[i];
  end
  // bits 4 and 10 are unrelated status set high to test the decode (R6)
  assign lock_stat = 16'h0410 | (16'(lk) << 5);

  // ---- scoreboard ----
  typedef struct {
    int kind;
    string req;
    logic [NP-1:0] mode, prst;
    logic [NP*NOW-1:0] od;
    logic [NP*NRW-1:0] rf;
    logic [NP*NFW-1:0] fb;
    logic [NP*BWW-1:0] bw;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  logic [NP-1:0] cur_mask = '0;
  bit finished = 0;

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor: pops one expected item per completion
  always @(negedge clk) begin
    if (rst_n === 1'b1 && (done || err)) begin
      if (q.size() == 0) chk("R1", "unexpected completion", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(e.req, "err flag", err, (e.kind != K_OK));
        chk(e.req, "done flag", done, (e.kind == K_OK));
        chk(e.req, "mode", pll_mode, e.mode);
        chk(e.req, "reset", pll_rst, e.prst);
        chk(e.req, "od field", pll_od, e.od);
        chk(e.req, "ref field", pll_ref, e.rf);
        chk(e.req, "fb field", pll_fb, e.fb);
        chk(e.req, "bw field", pll_bw, e.bw);
      end
    end
  end

  // ordering monitors
  logic [NP-1:0] p_mode, p_rst;
  logic [NP*NOW-1:0] p_od;
  logic [NP*NRW-1:0] p_rf;
  logic [NP*NFW-1:0] p_fb;
  logic [NP*BWW-1:0] p_bw;
  int hlen [NP];
  bit started = 0;

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (started) begin
        for (int i = 0; i < NP; i++) begin
          if ({pll_od[i*NOW +: NOW], pll_ref[i*NRW +: NRW], pll_fb[i*NFW +: NFW], pll_bw[i*BWW +: BWW]} !==
              {p_od[i*NOW +: NOW], p_rf[i*NRW +: NRW], p_fb[i*NFW +: NFW], p_bw[i*BWW +: BWW]})
            chk("R3", "field write while reset high", pll_rst[i], 1);
          if (pll_rst[i] && !p_rst[i])
            chk("R3", "mode bypassed at reset rise", pll_mode[i], 0);
          if (pll_mode[i] && !p_mode[i]) begin
            chk("R6", "lock high at un-bypass", lk[i], 1);
            chk("R8", "all targets locked at un-bypass", lk & cur_mask, cur_mask);
            chk("R6", "done with un-bypass", done, 1);
          end
          if (pll_rst[i]) hlen[i]++;
          else if (p_rst[i]) begin
            n_chk++;
            if (hlen[i] < SUS*CMHZ || hlen[i] > SUS*CMHZ + 4) begin
              n_fail++;
              $display("FAIL R5 reset length act=%0d exp=%0d..%0d", hlen[i], SUS*CMHZ, SUS*CMHZ+4);
            end
            hlen[i] = 0;
          end
        end
      end
      started = 1;
      p_mode = pll_mode; p_rst = pll_rst;
      p_od = pll_od; p_rf = pll_ref; p_fb = pll_fb; p_bw = pll_bw;
    end
  end

  // watchdog
  int wd = 0;
  always @(negedge clk) begin
    wd++;
    if (wd == 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // driver
  task automatic run_req(input int a, input int b, input bit pair,
                         input int nr, input int nf, input int no,
                         input int kind, input string req,
                         input bit poke, input int poke_idx);
    exp_t e;
    logic [NFW-1:0] snap_poke;
    logic [NP-1:0] m;
    while (busy) @(negedge clk);
    m = '0;
    if (kind != K_BAD) begin
      m[a] = 1'b1;
      if (pair) m[b] = 1'b1;
    end
    e.kind = kind; e.req = req;
    e.mode = pll_mode; e.prst = pll_rst;
    e.od = pll_od; e.rf = pll_ref; e.fb = pll_fb; e.bw = pll_bw;
    for (int i = 0; i < NP; i++) begin
      if (m[i]) begin
        e.mode[i] = (kind == K_OK);
        e.prst[i] = 1'b0;
        e.od[i*NOW +: NOW] = NOW'(no - 1);
        e.rf[i*NRW +: NRW] = NRW'(nr - 1);
        e.fb[i*NFW +: NFW] = NFW'(nf - 1);
        e.bw[i*BWW +: BWW] = BWW'((nf >> 1) - 1);
      end
    end
    snap_poke = pll_fb[poke_idx*NFW +: NFW];
    q.push_back(e);
    cur_mask = m;
    req_idx_a = 3'(a); req_idx_b = 3'(b); req_pair = pair;
    req_nr = NRW'(nr); req_nf = NFW'(nf); req_no = (NOW+1)'(no);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1", "busy after accept", busy, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      req_idx_a = 3'(poke_idx); req_pair = 1'b0;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    if (poke) begin
      repeat (600) @(negedge clk);
      chk("R1", "idle after ignored request", busy, 0);
      chk("R9", "untouched PLL fb field", pll_fb[poke_idx*NFW +: NFW], snap_poke);
    end
  endtask

  initial begin
    for (int i = 0; i < NP; i++) begin
      lcnt[i] = 0; ldly[i] = 40; hlen[i] = 0;
    end
    dead = '0;
    req_valid = 0; req_pair = 0; req_idx_a = 0; req_idx_b = 0;
    req_nr = 0; req_nf = 0; req_no = 0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "busy", busy, 0);
    chk("R10", "done/err", {done, err}, 0);
    chk("R10", "mode", pll_mode, {NP{1'b1}});
    chk("R10", "reset", pll_rst, 0);
    chk("R10", "fields", {pll_od, pll_ref, pll_fb[0 +: 32]}, 0);
    repeat (60) @(negedge clk);

    run_req(0, 0, 0, 1, 50, 2, K_OK, "R4", 0, 0);
    run_req(4, 0, 0, 2, 100, 1, K_OK, "R6", 0, 0);
    run_req(1, 0, 0, 3, 55, 16, K_OK, "R2", 0, 0);   // VCO 440 MHz, out 27.5 MHz
    run_req(1, 0, 0, 3, 54, 16, K_BAD, "R2", 0, 0);  // VCO 432 MHz
    run_req(3, 0, 0, 6, 550, 1, K_OK, "R2", 0, 0);   // VCO 2200 MHz
    run_req(3, 0, 0, 6, 551, 1, K_BAD, "R2", 0, 0);
    run_req(2, 0, 0, 1, 50, 3, K_BAD, "R2", 0, 0);   // odd NO
    run_req(2, 0, 0, 1, 50, 0, K_BAD, "R2", 0, 0);
    run_req(2, 0, 0, 1, 50, 18, K_BAD, "R2", 0, 0);
    run_req(2, 0, 0, 0, 50, 2, K_BAD, "R2", 0, 0);   // NR zero
    run_req(5, 0, 0, 1, 50, 2, K_BAD, "R2", 0, 0);   // index out of range
    run_req(1, 1, 1, 1, 50, 2, K_BAD, "R8", 0, 0);   // duplicate pair
    run_req(1, 7, 1, 1, 50, 2, K_BAD, "R8", 0, 0);

    dead[2] = 1'b1;
    run_req(2, 0, 0, 1, 60, 2, K_TMO, "R7", 0, 0);
    dead[2] = 1'b0;
    repeat (60) @(negedge clk);
    run_req(2, 0, 0, 1, 60, 4, K_OK, "R7", 0, 0);

    ldly[3] = 150;
    run_req(2, 3, 1, 2, 150, 2, K_OK, "R8", 0, 0);
    ldly[3] = 40;

    run_req(0, 0, 0, 1, 40, 2, K_OK, "R1", 1, 1);    // second request while busy

    repeat (10) @(negedge clk);
    chk("R1", "queue drained", q.size(), 0);
    finish_run();
  end

endmodule